// File: doc/BRIEF.md
# Frame-Referenced Deserializer Word Aligner

This block sits behind a set of 1:8 deserializers that capture one frame-clock lane and several data lanes on a single recovered bit clock. The bit clock is centred in the data eye, and the frame clock toggles exactly on byte boundaries. After the deserializers start, the position of the byte boundary inside each parallel word is unknown.

The aligner watches the parallel frame-clock word on every divided-clock cycle. While that word differs from the expected frame shape, the aligner issues single-cycle slip requests. Each request moves every deserializer's output window by one bit. Because the same request drives all deserializers, the data lanes take the same boundary as the frame lane. Once the frame word has matched for a run of consecutive cycles, the aligner reports lock, and it qualifies the registered data words as valid.

When the frame word is lost while locked, the aligner drops lock and starts searching again. When a full cycle of slips passes without a match, it flags an alignment error and restarts the search.

Top module: `frame_word_aligner`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `bitslip`, `locked`, `data_valid` and `align_err` are low.
- R2: While searching, a frame word that differs from 8'hF0 (bit 7 is the first bit received) produces a `bitslip` pulse exactly one cycle long, in the cycle after that word is sampled.
- R3: After a slip request, the next 3 frame words are not evaluated. Under continuous mismatch, slip requests are therefore spaced exactly 4 cycles apart.
- R4: `locked` rises in the cycle after the 4th consecutive sampled frame word equal to 8'hF0. No slip is issued during that run.
- R5: A mismatch after fewer than 4 matching words clears the run, and that mismatch triggers a slip request.
- R6: The search counts up to 8 slips. If the next evaluated word after the 8th slip still mismatches, `align_err` pulses for one cycle, no slip is issued on that cycle, and the slip count restarts. The search then continues and can still reach lock.
- R7: A single mismatching word while locked leaves `locked` high. Two consecutive mismatches clear `locked` in the cycle after the second one, and slipping resumes on the next mismatch.
- R8: `data_out` carries `data_words` delayed by one cycle. `data_valid` equals `locked` on every cycle.
- R9: The slip requests realign all lanes together. Once locked, each data lane of `data_out` carries the transmitted bytes on their true boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided (parallel-word) clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_word | input | 8 | Deserialized frame-clock lane word |
| data_words | input | LANES*8 | Deserialized data lane words, lane 0 in the low byte |
| bitslip | output | 1 | Single-cycle slip request shared by all deserializers |
| data_out | output | LANES*8 | Registered data lane words |
| data_valid | output | 1 | Qualifies `data_out`; high exactly while locked |
| locked | output | 1 | Frame boundary found and held |
| align_err | output | 1 | One-cycle pulse when a full slip cycle found no match |

## Verification
The frame word is sampled on a rising edge, and every result of that sample appears one register later: `bitslip`, `locked`, `align_err`, `data_out` and `data_valid` all change right after the edge that sampled the input that caused them. The bench presents each frame word before an edge. It reads the outputs a quarter period after that same edge, so each check lands in the first cycle where the result is due. The behavioural serializer shifts its window on the falling edge that follows a slip request, which falls inside the 3-cycle settle window. Slip counts and the spacing between slips are tallied on falling edges. The 8-slip error case is checked on the exact cycle number counted from reset release.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } align_state_e;

endpackage

// File: rtl/fwa_settle_timer.sv
module fwa_settle_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expiring
);
  localparam int TW = $clog2(SETTLE_CYC + 1) + 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TW'(SETTLE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expiring = (cnt_q == TW'(1));
endmodule

// File: rtl/fwa_lock_ctrl.sv
module fwa_lock_ctrl
  import fwa_pkg::*;
#(
  parameter int MAX_SLIPS  = 8,
  parameter int LOCK_RUN   = 4,
  parameter int UNLOCK_RUN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic settle_done,
  output logic settle_load,
  output logic slip_req,
  output logic lock_flag,
  output logic lock_next,
  output logic err_pulse
);
  localparam int SW = $clog2(MAX_SLIPS + 1);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam int MW = $clog2(UNLOCK_RUN + 1);

  align_state_e state_q, state_d;
  logic [SW-1:0] slips_q, slips_d;
  logic [RW-1:0] run_q, run_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          slip_d, err_d;

  always_comb begin
    state_d     = state_q;
    slips_d     = slips_q;
    run_d       = run_q;
    miss_d      = miss_q;
    slip_d      = 1'b0;
    err_d       = 1'b0;
    lock_next   = lock_flag;
    settle_load = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (match) begin
          if (run_q == RW'(LOCK_RUN - 1)) begin
            state_d   = ST_HOLD;
            lock_next = 1'b1;
            run_d     = '0;
            miss_d    = '0;
            slips_d   = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d       = '0;
          settle_load = 1'b1;
          state_d     = ST_SETTLE;
          if (slips_q == SW'(MAX_SLIPS)) begin
            err_d   = 1'b1;
            slips_d = '0;
          end else begin
            slip_d  = 1'b1;
            slips_d = slips_q + 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (settle_done) state_d = ST_HUNT;
      end
      ST_HOLD: begin
        if (match) begin
          miss_d = '0;
        end else if (miss_q == MW'(UNLOCK_RUN - 1)) begin
          miss_d    = '0;
          lock_next = 1'b0;
          slips_d   = '0;
          state_d   = ST_HUNT;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HUNT;
      slips_q   <= '0;
      run_q     <= '0;
      miss_q    <= '0;
      slip_req  <= 1'b0;
      err_pulse <= 1'b0;
      lock_flag <= 1'b0;
    end else begin
      state_q   <= state_d;
      slips_q   <= slips_d;
      run_q     <= run_d;
      miss_q    <= miss_d;
      slip_req  <= slip_d;
      err_pulse <= err_d;
      lock_flag <= lock_next;
    end
  end
endmodule

// File: rtl/fwa_lane_stage.sv
module fwa_lane_stage #(
  parameter int LANES  = 2,
  parameter int WORD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*WORD_W-1:0] lanes_in,
  input  logic                    qualify,
  output logic [LANES*WORD_W-1:0] lanes_out,
  output logic                    lanes_valid
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lanes_out[l*WORD_W +: WORD_W] <= '0;
      else     lanes_out[l*WORD_W +: WORD_W] <= lanes_in[l*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lanes_valid <= 1'b0;
    else     lanes_valid <= qualify;
  end
endmodule

// File: rtl/frame_word_aligner.sv
module frame_word_aligner #(
  parameter int          LANES      = 2,
  parameter int          WORD_W     = 8,
  parameter logic [7:0]  FRAME_PAT  = 8'hF0,
  parameter int          SETTLE_CYC = 3,
  parameter int          MAX_SLIPS  = 8,
  parameter int          LOCK_RUN   = 4,
  parameter int          UNLOCK_RUN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WORD_W-1:0]       frame_word,
  input  logic [LANES*WORD_W-1:0] data_words,
  output logic                    bitslip,
  output logic [LANES*WORD_W-1:0] data_out,
  output logic                    data_valid,
  output logic                    locked,
  output logic                    align_err
);
  logic match, settle_load, settle_done, lock_next;

  assign match = (frame_word == WORD_W'(FRAME_PAT));

  fwa_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (settle_load),
    .expiring (settle_done)
  );

  fwa_lock_ctrl #(
    .MAX_SLIPS  (MAX_SLIPS),
    .LOCK_RUN   (LOCK_RUN),
    .UNLOCK_RUN (UNLOCK_RUN)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .match       (match),
    .settle_done (settle_done),
    .settle_load (settle_load),
    .slip_req    (bitslip),
    .lock_flag   (locked),
    .lock_next   (lock_next),
    .err_pulse   (align_err)
  );

  fwa_lane_stage #(.LANES(LANES), .WORD_W(WORD_W)) u_lanes (
    .clk         (clk),
    .rst         (rst),
    .lanes_in    (data_words),
    .qualify     (lock_next),
    .lanes_out   (data_out),
    .lanes_valid (data_valid)
  );
endmodule

// File: rtl/frame_word_aligner_checker.sv
module frame_word_aligner_checker #(
  parameter int         LANES      = 2,
  parameter int         WORD_W     = 8,
  parameter logic [7:0] FRAME_PAT  = 8'hF0,
  parameter int         SETTLE_CYC = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [WORD_W-1:0]       frame_word,
  input logic [LANES*WORD_W-1:0] data_words,
  input logic                    bitslip,
  input logic [LANES*WORD_W-1:0] data_out,
  input logic                    data_valid,
  input logic                    locked,
  input logic                    align_err
);
  localparam int GW = $clog2(SETTLE_CYC + 2) + 1;
  logic [GW-1:0] since_slip;
  logic          seen_slip;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_slip <= '0;
      seen_slip  <= 1'b0;
    end else if (bitslip) begin
      since_slip <= GW'(1);
      seen_slip  <= 1'b1;
    end else if (since_slip <= GW'(SETTLE_CYC)) begin
      since_slip <= since_slip + 1'b1;
    end
  end

  assert_slip_single_R2: assert property (@(posedge clk) disable iff (rst)
    bitslip |=> !bitslip);

  assert_slip_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (bitslip && seen_slip) |-> (since_slip > GW'(SETTLE_CYC)));

  assert_lock_on_match_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(frame_word) == WORD_W'(FRAME_PAT)));

  assert_no_slip_while_locked_R4: assert property (@(posedge clk) disable iff (rst)
    locked |-> !bitslip);

  assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
    align_err |=> !align_err);

  assert_err_not_slip_R6: assert property (@(posedge clk) disable iff (rst)
    align_err |-> !bitslip);

  assert_unlock_on_miss_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(frame_word) != WORD_W'(FRAME_PAT)));

  assert_data_delay_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (data_out == $past(data_words)));

  assert_valid_is_lock_R8: assert property (@(posedge clk) disable iff (rst)
    data_valid == locked);
endmodule

bind frame_word_aligner frame_word_aligner_checker #(
  .LANES(LANES), .WORD_W(WORD_W), .FRAME_PAT(FRAME_PAT), .SETTLE_CYC(SETTLE_CYC)
) u_checker (
  .clk(clk), .rst(rst), .frame_word(frame_word), .data_words(data_words),
  .bitslip(bitslip), .data_out(data_out), .data_valid(data_valid),
  .locked(locked), .align_err(align_err)
);

// File: tb/frame_word_aligner_bench.sv
module frame_word_aligner_bench;
  localparam int LANES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]       frame_word;
  logic [LANES*8-1:0] data_words;
  logic bitslip, data_valid, locked, align_err;
  logic [LANES*8-1:0] data_out;

  always #10 clk = ~clk;

  frame_word_aligner u_frame_word_aligner (
    .clk(clk), .rst(rst), .frame_word(frame_word), .data_words(data_words),
    .bitslip(bitslip), .data_out(data_out), .data_valid(data_valid),
    .locked(locked), .align_err(align_err)
  );

  int checks = 0;
  int errors = 0;

  // behavioural serializer + deserializer with shared bitslip
  int init_off = 5;
  int off = 0;
  int word_idx = 0;
  int cyc = 0;
  int slips = 0;
  int errs = 0;
  int last_slip = -1;
  int bad_gap = 0;
  logic       ovr_en = 1'b0;
  logic [7:0] ovr_val = 8'h00;

  function automatic logic [7:0] dval(int n, int l);
    return 8'((n * 37 + l * 91 + 5) & 255);
  endfunction

  function automatic logic [7:0] window(logic [7:0] a, logic [7:0] b, int o);
    logic [15:0] t;
    t = {a, b} << o;
    return t[15:8];
  endfunction

  assign frame_word = ovr_en ? ovr_val : window(8'hF0, 8'hF0, off);
  for (genvar l = 0; l < LANES; l++) begin : g_tx
    assign data_words[l*8 +: 8] = window(dval(word_idx, l), dval(word_idx + 1, l), off);
  end

  always @(negedge clk) begin
    if (rst) begin
      off = init_off; word_idx = 0; cyc = 0;
      slips = 0; errs = 0; last_slip = -1; bad_gap = 0;
    end else begin
      if (bitslip) begin
        off = (off + 1) % 8;
        slips++;
        if (last_slip >= 0 && cyc - last_slip != 4) bad_gap++;
        last_slip = cyc;
      end
      if (align_err) errs++;
      word_idx++;
      cyc++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int o, bit ov, logic [7:0] v);
    rst = 1'b1; init_off = o; ovr_en = ov; ovr_val = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(logic [7:0] v);
    ovr_val = v;
    @(posedge clk);
    #5;
  endtask

  task automatic wait_lock(string req, int limit);
    int n = 0;
    while (!locked && n < limit) begin
      @(posedge clk); #5; n++;
    end
    check(locked == 1'b1, req, int'(locked), 1);
  endtask

  task automatic test_reset();
    rst = 1'b1; ovr_en = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    check(bitslip == 0 && locked == 0, "R1", int'(bitslip) + int'(locked), 0);
    check(data_valid == 0 && align_err == 0, "R1", int'(data_valid) + int'(align_err), 0);
  endtask

  task automatic test_natural_align();
    do_reset(5, 1'b0, 8'h00);
    check(bitslip == 0 && locked == 0, "R1", int'(bitslip) + int'(locked), 0);
    wait_lock("R4", 200);
    check(slips == 3, "R2", slips, 3);
    check(bad_gap == 0, "R3", bad_gap, 0);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #5;
      check(data_valid == 1'b1, "R8", int'(data_valid), 1);
      for (int l = 0; l < LANES; l++)
        check(data_out[l*8 +: 8] == dval(word_idx, l), "R9",
              int'(data_out[l*8 +: 8]), int'(dval(word_idx, l)));
    end
  endtask

  task automatic test_lock_run_and_unlock();
    do_reset(0, 1'b1, 8'hF0);
    step(8'hF0); step(8'hF0); step(8'hF0);
    check(locked == 1'b0, "R4", int'(locked), 0);
    step(8'hF0);
    check(locked == 1'b1, "R4", int'(locked), 1);
    check(data_valid == 1'b1, "R8", int'(data_valid), 1);
    check(slips == 0, "R4", slips, 0);
    step(8'h00);
    check(locked == 1'b1, "R7", int'(locked), 1);
    step(8'hF0);
    step(8'h00);
    check(locked == 1'b1, "R7", int'(locked), 1);
    step(8'h00);
    check(locked == 1'b0, "R7", int'(locked), 0);
    check(data_valid == 1'b0, "R8", int'(data_valid), 0);
    step(8'h00);
    check(bitslip == 1'b1, "R7", int'(bitslip), 1);
  endtask

  task automatic test_partial_run();
    do_reset(0, 1'b1, 8'hF0);
    step(8'hF0); step(8'hF0); step(8'hF0);
    step(8'h3C);
    check(bitslip == 1'b1, "R5", int'(bitslip), 1);
    check(locked == 1'b0, "R5", int'(locked), 0);
    step(8'h3C);
    check(bitslip == 1'b0, "R2", int'(bitslip), 0);
  endtask

  task automatic test_slip_exhaust();
    do_reset(0, 1'b1, 8'h00);
    for (int i = 0; i < 34; i++) begin
      step(8'h00);
      if (i == 31) check(align_err == 1'b0, "R6", int'(align_err), 0);
      if (i == 32) begin
        check(align_err == 1'b1, "R6", int'(align_err), 1);
        check(bitslip == 1'b0, "R6", int'(bitslip), 0);
      end
    end
    check(slips == 8, "R6", slips, 8);
    check(errs == 1, "R6", errs, 1);
    check(bad_gap == 0, "R3", bad_gap, 0);
    step(8'h00); step(8'h00); step(8'h00);
    check(bitslip == 1'b1, "R6", int'(bitslip), 1);
    ovr_en = 1'b0;
    wait_lock("R6", 200);
  endtask

  initial begin
    test_reset();
    test_natural_align();
    test_lock_run_and_unlock();
    test_partial_run();
    test_slip_exhaust();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule